// File: doc/BRIEF.md
# Register Write Access Guard

This block sits in front of a group of protected target registers and decides, one request at a time, whether a write may land. Every request carries a 4-bit domain number, a privileged flag and a secure flag. A write to the protected group lands only when the requester's domain is on a 16-entry allow list and it passes a privilege gate and a security gate. A refused write is dropped and raises a one-cycle error pulse.

The policy lives in a 32-bit authentication register that the same request port can write. The register has two enables that relax the gates. User-write enable (bit 8) lets unprivileged writes through. Non-secure enable (bit 9) lets non-secure writes through. The allow list occupies bits 31:16, with bit 16+n standing for domain n. Two sticky locks freeze parts of the register independently. The gate lock (bit 11) freezes itself and both enables. The list lock (bit 15) freezes itself and the allow list. Only reset opens a lock again. The authentication register accepts writes only from requesters that are both secure and privileged.

A request is sampled on a rising edge, and its verdict appears on the outputs for exactly the following cycle. The verdict state machine has five states:
- `VD_IDLE`: no request was seen.
- `VD_TGT_GRANT`: a target write was allowed.
- `VD_TGT_DENY`: a target write was refused.
- `VD_CFG_TAKE`: an authentication write was accepted.
- `VD_CFG_DENY`: an authentication write was refused.

On every edge the machine moves to the state that matches the request sampled there, or to `VD_IDLE` when there is none. Each lock group is a two-state machine. It moves from `LK_OPEN` to `LK_SEALED` when an accepted authentication write carries a 1 in its lock bit. From `LK_SEALED` it leaves only through reset.

Top module: `wr_access_guard`

## Requirements
- R1: After reset the authentication register reads zero, both locks are open, and `tgt_wr_allow_o` and `wr_err_o` are low. With the list empty, every target write is refused.
- R2: A target write (`req_cfg_i`=0) is allowed only if bit 16+d of the authentication register is 1, where d is `req_domain_i`. When allowed, `tgt_wr_allow_o` is high for exactly the one cycle after the sampling edge.
- R3: While bit 8 (user-write enable) is 0, a target write with `req_priv_i`=0 is refused. While bit 8 is 1, the privilege flag does not matter.
- R4: While bit 9 (non-secure enable) is 0, a target write with `req_secure_i`=0 is refused. While bit 9 is 1, the security flag does not matter.
- R5: A refused target write raises `wr_err_o` for the one cycle after the sampling edge, with `tgt_wr_allow_o` low. The two outputs are never high together.
- R6: An authentication write (`req_cfg_i`=1) is accepted only when `req_priv_i` and `req_secure_i` are both 1. Otherwise `wr_err_o` pulses and the register keeps its value.
- R7: Once bit 11 (gate lock) reads 1, bits 8, 9 and 11 ignore all further writes until reset.
- R8: Once bit 15 (list lock) reads 1, bits 15 and 31:16 ignore all further writes until reset.
- R9: The two locks are independent. A set gate lock leaves the list writable, and a set list lock leaves the enables writable.
- R10: `auth_q_o` shows bit 8 user-write enable, bit 9 non-secure enable, bit 11 gate lock, bit 15 list lock and bits 31:16 the allow list. Every other bit reads 0, whatever was written to it. An accepted write is visible one cycle after its sampling edge.
- R11: In a cycle after an edge with no request, both `tgt_wr_allow_o` and `wr_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A write request is present this cycle |
| req_cfg_i | input | 1 | 1: write to the authentication register; 0: write to the protected targets |
| req_data_i | input | 32 | Write data, used only for authentication writes |
| req_domain_i | input | 4 | Domain number of the requester |
| req_priv_i | input | 1 | Requester is privileged |
| req_secure_i | input | 1 | Requester is secure |
| tgt_wr_allow_o | output | 1 | One-cycle grant for the protected target write |
| wr_err_o | output | 1 | One-cycle pulse for any refused write |
| auth_q_o | output | 32 | Current authentication register contents |

## Verification
The hardest situation to reach from the ports is a lock that is already set while the other lock is still open, followed by later writes that try to undo it. Random stimulus on its own sets both locks within a few writes, and after that nothing can change. The stimulus therefore sets a lock bit in only about one random authentication write in sixteen. It resets the block between random phases so the locks reopen. Directed sequences seal each lock on its own and then try to clear it, while still changing the other group.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;

    localparam int DATA_W   = 32;
    localparam int DOM_W    = 4;
    localparam int NUM_DOM  = 1 << DOM_W;

    localparam int BIT_USER  = 8;
    localparam int BIT_NS    = 9;
    localparam int BIT_GLOCK = 11;
    localparam int BIT_LLOCK = 15;
    localparam int LIST_LSB  = 16;

    localparam int GATE_W = 2;

    typedef enum logic [2:0] {
        VD_IDLE,
        VD_TGT_GRANT,
        VD_TGT_DENY,
        VD_CFG_TAKE,
        VD_CFG_DENY
    } verdict_e;

    typedef enum logic {
        LK_OPEN,
        LK_SEALED
    } lock_e;

    typedef struct packed {
        logic ns_en;
        logic user_en;
    } gate_t;

endpackage

// File: rtl/wr_guard_lock.sv
module wr_guard_lock
    import wr_guard_pkg::*;
#(
    parameter int FIELD_W = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               upd_i,
    input  logic               lock_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [FIELD_W-1:0] field_o,
    output logic               sealed_o
);

    lock_e              state_q, state_d;
    logic [FIELD_W-1:0] field_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (upd_i && lock_i) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LK_OPEN;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           field_q <= '0;
        else if (upd_i && state_q == LK_OPEN)  field_q <= field_i;
    end

    assign field_o  = field_q;
    assign sealed_o = (state_q == LK_SEALED);

    AST_SEAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sealed_o |=> sealed_o);  // R7
    AST_SEALED_FIELD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sealed_o && upd_i) |=> $stable(field_o));  // R8

endmodule

// File: rtl/wr_guard_policy.sv
module wr_guard_policy
    import wr_guard_pkg::*;
#(
    parameter int N_DOM = 16,
    localparam int DW   = $clog2(N_DOM)
) (
    input  gate_t            gate_i,
    input  logic [N_DOM-1:0] list_i,
    input  logic [DW-1:0]    domain_i,
    input  logic             priv_i,
    input  logic             secure_i,
    output logic             tgt_ok_o,
    output logic             cfg_ok_o
);

    logic list_hit, priv_ok, sec_ok;

    always_comb begin
        list_hit = list_i[domain_i];
        priv_ok  = priv_i   | gate_i.user_en;
        sec_ok   = secure_i | gate_i.ns_en;
        tgt_ok_o = list_hit & priv_ok & sec_ok;
        cfg_ok_o = priv_i & secure_i;
    end

endmodule

// File: rtl/wr_access_guard.sv
module wr_access_guard
    import wr_guard_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int ID_W = DOM_W,
    localparam int N_DOM = 1 << ID_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_valid_i,
    input  logic            req_cfg_i,
    input  logic [D_W-1:0]  req_data_i,
    input  logic [ID_W-1:0] req_domain_i,
    input  logic            req_priv_i,
    input  logic            req_secure_i,
    output logic            tgt_wr_allow_o,
    output logic            wr_err_o,
    output logic [D_W-1:0]  auth_q_o
);

    verdict_e         verdict_q, verdict_d;
    logic             tgt_ok, cfg_ok, cfg_upd;
    gate_t            gate_new, gate_q;
    logic [N_DOM-1:0] list_q;
    logic             gate_sealed, list_sealed;
    logic             data_unused;

    assign gate_new.user_en = req_data_i[BIT_USER];
    assign gate_new.ns_en   = req_data_i[BIT_NS];
    assign cfg_upd          = req_valid_i & req_cfg_i & cfg_ok;
    assign data_unused      = ^{req_data_i[BIT_USER-1:0], req_data_i[BIT_GLOCK-1:BIT_NS+1],
                                req_data_i[BIT_LLOCK-1:BIT_GLOCK+1]};

    wr_guard_lock #(.FIELD_W(GATE_W)) u_gate_lock (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .upd_i    (cfg_upd),
        .lock_i   (req_data_i[BIT_GLOCK]),
        .field_i  (gate_new),
        .field_o  (gate_q),
        .sealed_o (gate_sealed)
    );

    wr_guard_lock #(.FIELD_W(N_DOM)) u_list_lock (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .upd_i    (cfg_upd),
        .lock_i   (req_data_i[BIT_LLOCK]),
        .field_i  (req_data_i[LIST_LSB +: N_DOM]),
        .field_o  (list_q),
        .sealed_o (list_sealed)
    );

    wr_guard_policy #(.N_DOM(N_DOM)) u_policy (
        .gate_i   (gate_q),
        .list_i   (list_q),
        .domain_i (req_domain_i),
        .priv_i   (req_priv_i),
        .secure_i (req_secure_i),
        .tgt_ok_o (tgt_ok),
        .cfg_ok_o (cfg_ok)
    );

    always_comb begin
        if (!req_valid_i)   verdict_d = VD_IDLE;
        else if (req_cfg_i) verdict_d = cfg_ok ? VD_CFG_TAKE  : VD_CFG_DENY;
        else                verdict_d = tgt_ok ? VD_TGT_GRANT : VD_TGT_DENY;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) verdict_q <= VD_IDLE;
        else         verdict_q <= verdict_d;
    end

    always_comb begin
        tgt_wr_allow_o = 1'b0;
        wr_err_o       = 1'b0;
        unique case (verdict_q)
            VD_IDLE:      ;
            VD_TGT_GRANT: tgt_wr_allow_o = 1'b1;
            VD_TGT_DENY:  wr_err_o       = 1'b1;
            VD_CFG_TAKE:  ;
            VD_CFG_DENY:  wr_err_o       = 1'b1;
            default:      ;
        endcase
    end

    always_comb begin
        auth_q_o                   = '0;
        auth_q_o[BIT_USER]         = gate_q.user_en;
        auth_q_o[BIT_NS]           = gate_q.ns_en;
        auth_q_o[BIT_GLOCK]        = gate_sealed;
        auth_q_o[BIT_LLOCK]        = list_sealed;
        auth_q_o[LIST_LSB +: N_DOM] = list_q;
    end

    AST_ALLOW_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tgt_wr_allow_o && wr_err_o));  // R5
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (!tgt_wr_allow_o && !wr_err_o));  // R11
    AST_CFG_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_cfg_i && !(req_priv_i && req_secure_i)) |=> (wr_err_o && $stable(auth_q_o)));  // R6
    AST_USER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_cfg_i && !req_priv_i && !auth_q_o[BIT_USER]) |=> (!tgt_wr_allow_o && wr_err_o));  // R3
    AST_NS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_cfg_i && !req_secure_i && !auth_q_o[BIT_NS]) |=> (!tgt_wr_allow_o && wr_err_o));  // R4
    AST_LIST_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_cfg_i && !auth_q_o[LIST_LSB + int'(req_domain_i)]) |=> !tgt_wr_allow_o);  // R2
    AST_GLOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        auth_q_o[BIT_GLOCK] |=> $stable(auth_q_o[BIT_GLOCK:BIT_USER]));  // R7

endmodule

// File: tb/wr_access_guard_bench.sv
`timescale 1ns/1ps
module wr_access_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, cfg = 1'b0, priv = 1'b0, sec = 1'b0;
    logic [31:0] data = '0;
    logic [3:0]  dom = '0;
    logic        allow, err;
    logic [31:0] auth;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        m_user, m_ns, m_gl, m_ll;
    logic [15:0] m_list;

    always #2.5 clk = ~clk;

    wr_access_guard u_wr_access_guard (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_cfg_i(cfg),
        .req_data_i(data), .req_domain_i(dom), .req_priv_i(priv), .req_secure_i(sec),
        .tgt_wr_allow_o(allow), .wr_err_o(err), .auth_q_o(auth)
    );

    function automatic logic [31:0] model_auth();
        logic [31:0] v = '0;
        v[8] = m_user; v[9] = m_ns; v[11] = m_gl; v[15] = m_ll; v[31:16] = m_list;
        return v;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_user = 0; m_ns = 0; m_gl = 0; m_ll = 0; m_list = '0;
        @(posedge clk); #1;
        chk({30'd0, allow, err}, 32'd0, "R1 outputs after reset");
        chk(auth, 32'd0, "R1 register after reset");
    endtask

    task automatic req(input logic c, input logic [31:0] d, input logic [3:0] dm,
                       input logic p, input logic s, input string tag_in);
        logic  e_allow, e_err;
        string tag;
        @(negedge clk);
        valid = 1'b1; cfg = c; data = d; dom = dm; priv = p; sec = s;
        tag = tag_in;
        if (c) begin
            e_allow = 0;
            e_err   = !(p && s);
            if (tag == "") tag = "R6";
            if (p && s) begin
                if (!m_gl) begin m_user = d[8]; m_ns = d[9]; m_gl = d[11]; end
                if (!m_ll) begin m_list = d[31:16]; m_ll = d[15]; end
            end
        end else begin
            e_allow = m_list[dm] && (p || m_user) && (s || m_ns);
            e_err   = !e_allow;
            if (tag == "") begin
                if (!m_list[dm])           tag = "R2";
                else if (!(p || m_user))   tag = "R3";
                else if (!(s || m_ns))     tag = "R4";
                else                       tag = "R2";
            end
        end
        @(posedge clk); #1;
        chk({31'd0, allow}, {31'd0, e_allow}, {tag, " allow"});
        chk({31'd0, err},   {31'd0, e_err},   {tag, " R5 error"});
        chk(auth, model_auth(), {tag, " R10 register"});
    endtask

    task automatic idle_check();
        @(negedge clk);
        valid = 1'b0;
        @(posedge clk); #1;
        chk({30'd0, allow, err}, 32'd0, "R11 idle cycle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        do_reset();
        // empty list refuses everything
        req(0, 0, 4'd3, 1, 1, "R1 empty list");
        // cfg writes from unqualified requesters
        req(1, 32'hFFFF_0B00, 0, 0, 1, "R6 user cfg");
        req(1, 32'hFFFF_0B00, 0, 1, 0, "R6 nonsecure cfg");
        // reserved bits written as ones read back zero
        req(1, 32'h0008_04FF, 0, 1, 1, "R10 reserved");
        req(0, 0, 4'd3, 1, 1, "R2 listed grant");
        req(0, 0, 4'd4, 1, 1, "R2 unlisted");
        req(0, 0, 4'd3, 0, 1, "R3 user blocked");
        req(0, 0, 4'd3, 1, 0, "R4 nonsecure blocked");
        idle_check();
        req(1, 32'h8008_0300, 0, 1, 1, "R10 enables");
        req(0, 0, 4'd3, 0, 0, "R3 R4 relaxed");
        req(0, 0, 4'd15, 0, 1, "R2 domain 15");
        // seal the gates
        req(1, 32'h8008_0A00, 0, 1, 1, "R7 seal gates");
        req(1, 32'h0000_0300, 0, 1, 1, "R7 clear attempt");
        req(0, 0, 4'd15, 1, 0, "R7 gate frozen");
        req(0, 0, 4'd15, 0, 1, "R9 list still writable");
        // seal the list
        req(1, 32'h0010_8000, 0, 1, 1, "R8 seal list");
        req(1, 32'hFFFF_0000, 0, 1, 1, "R8 clear attempt");
        req(0, 0, 4'd4, 1, 1, "R8 list frozen");
        idle_check();
        // list lock alone keeps enables writable
        do_reset();
        req(1, 32'h0001_8000, 0, 1, 1, "R9 list seal only");
        req(1, 32'h0000_0300, 0, 1, 1, "R9 gates writable");
        req(0, 0, 4'd0, 0, 0, "R9 relaxed grant");
        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            do_reset();
            for (int i = 0; i < 150; i++) begin
                logic [31:0] d;
                logic        c;
                d = $urandom;
                if (($urandom % 16) != 0) d[11] = 1'b0;
                if (($urandom % 16) != 0) d[15] = 1'b0;
                c = (($urandom % 4) == 0);
                if (($urandom % 8) == 0) idle_check();
                else req(c, d, 4'($urandom), 1'($urandom), 1'($urandom), "");
            end
        end
        idle_check();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule